// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one atomic memory instruction at a time against a single synchronous memory port. A request names the operand width through an 8-bit opcode and the operation through an immediate. It also supplies a base register value, a signed 16-bit displacement, a source operand and the value of register zero. The unit reads the addressed word and computes the new value. It writes that value back unless a compare-exchange finds a mismatch. The lock output is held high for the whole read-modify-write window, so the memory side can keep other agents out of the word.

When a fetching variant, an exchange or a compare-exchange finishes, the unit presents the old memory contents as a write-back value. It raises one flag to say whether the value goes to the register file and a second flag to say whether the target is the source register or register zero. The surrounding pipeline pulses `start` while `busy` is low and takes the results in the single cycle where `done` is high. A request with an unknown encoding ends with an error flag and makes no memory access.

Top module: `amo_unit`

## Requirements
- R1: Opcode 0xdb works on the full 64-bit word and writes with byte mask 0xFF. Opcode 0xc3 works on the low 32 bits and writes with byte mask 0x0F, so the upper four bytes of memory stay unchanged.
- R2: Immediates 0x00, 0x40, 0x50 and 0xa0 store memory+src, memory|src, memory&src and memory^src. At `done`, `wb_en` is low.
- R3: Immediates 0x01, 0x41, 0x51 and 0xa1 change memory exactly as their even counterparts do. At `done` they assert `wb_en` with `wb_to_r0` low and place the old memory value on `wb_data`.
- R4: Immediate 0xe1 stores src into memory and returns the old value to the source register (`wb_en` high, `wb_to_r0` low).
- R5: Immediate 0xf1 with memory equal to r0 stores src and returns the old value with `wb_en` and `wb_to_r0` both high.
- R6: Immediate 0xf1 with memory different from r0 issues no write and leaves memory unchanged. It still returns the old value with `wb_to_r0` high.
- R7: Both the read and the write use the address base + sign-extended offset.
- R8: In 32-bit mode the returned old value is zero-extended, and compare-exchange compares only the low 32 bits of memory and r0.
- R9: An opcode other than 0xdb/0xc3, an immediate outside the ten listed codes, or any set bit above bit 7 of the immediate gives `err` high with `done` one cycle after `start`. No memory request is made and `wb_en` stays low.
- R10: The read request is made in the cycle after `start` and the write two cycles after the read. `done` is high for exactly one cycle, in the cycle after the write or, when no write is made, two cycles after the read. `lock` is high from the read through the write.
- R11: During and after reset, while idle, `busy`, `done`, `err`, `lock` and `mem_req` are low.
- R12: A `start` pulse that arrives while `busy` is high is ignored. It produces no extra `done` and no memory change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only while idle |
| opcode | input | 8 | Width-selecting opcode |
| imm | input | IMM_W | Operation code |
| base | input | ADDR_W | Destination register value |
| offset | input | OFF_W | Signed displacement |
| src_val | input | DATA_W | Source register value |
| r0_val | input | DATA_W | Register zero value (compare operand) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Unrecognised request, valid with done |
| lock | output | 1 | Memory word locked |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_wmask | output | DATA_W/8 | Byte write enables |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| wb_en | output | 1 | Write-back valid, with done |
| wb_to_r0 | output | 1 | Write-back target is register zero |
| wb_data | output | DATA_W | Old memory value to write back |

## Verification
The properties assume that memory answers every read with data in the next cycle and never stalls. The stimulus meets this with a zero-wait-state model that registers its read data on the request edge. The properties also assume that a write always follows a read of the same address and that an error path makes no access, and they check both of these timing relations. The bench keeps every address inside a small window of eight words, so the expected memory image can be followed exactly. It still hands the unit inputs that are not allowed, such as stray start pulses during an operation and unknown encodings, because the unit has to tolerate them.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam logic [7:0] OPC_WIDE   = 8'hdb;
    localparam logic [7:0] OPC_NARROW = 8'hc3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_MODIFY,
        ST_WRITE,
        ST_DONE
    } amo_state_t;

    typedef enum logic [2:0] {
        K_ADD,
        K_OR,
        K_AND,
        K_XOR,
        K_XCHG,
        K_CMPX
    } amo_kind_t;

    typedef struct packed {
        logic      legal;
        logic      narrow;
        logic      fetch;
        amo_kind_t kind;
    } amo_cmd_t;

    // Operation code in the low byte; bit 0 requests the old value back.
    function automatic amo_cmd_t amo_decode_fn(logic [7:0] opc, logic [7:0] op_lo, logic hi_clear);
        amo_cmd_t c;
        logic     known;
        c.kind   = K_ADD;
        c.fetch  = op_lo[0];
        c.narrow = (opc == OPC_NARROW);
        known    = 1'b1;
        case (op_lo)
            8'h00, 8'h01: c.kind = K_ADD;
            8'h40, 8'h41: c.kind = K_OR;
            8'h50, 8'h51: c.kind = K_AND;
            8'ha0, 8'ha1: c.kind = K_XOR;
            8'he1:        c.kind = K_XCHG;
            8'hf1:        c.kind = K_CMPX;
            default:      known  = 1'b0;
        endcase
        c.legal = known && hi_clear && ((opc == OPC_WIDE) || (opc == OPC_NARROW));
        return c;
    endfunction

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
#(
    parameter int IMM_W = 32
) (
    input  logic [7:0]       opcode,
    input  logic [IMM_W-1:0] imm,
    output amo_cmd_t         cmd
);
    logic hi_clear;

    always_comb begin
        hi_clear = (imm[IMM_W-1:8] == '0);
        cmd      = amo_decode_fn(opcode, imm[7:0], hi_clear);
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  amo_cmd_t          cmd,
    input  logic [DATA_W-1:0] mem_old,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] cmp,
    output logic [DATA_W-1:0] new_val,
    output logic [DATA_W-1:0] fetched,
    output logic              do_write
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LOW_ONES = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] m_op;
    logic [DATA_W-1:0] s_op;
    logic [DATA_W-1:0] c_op;
    logic [DATA_W-1:0] result;

    always_comb begin
        keep = cmd.narrow ? LOW_ONES : '1;
        m_op = mem_old & keep;
        s_op = src & keep;
        c_op = cmp & keep;
        case (cmd.kind)
            K_ADD:   result = m_op + s_op;
            K_OR:    result = m_op | s_op;
            K_AND:   result = m_op & s_op;
            K_XOR:   result = m_op ^ s_op;
            K_XCHG:  result = s_op;
            K_CMPX:  result = s_op;
            default: result = m_op;
        endcase
        new_val  = result & keep;
        fetched  = m_op;
        do_write = (cmd.kind != K_CMPX) || (m_op == c_op);
    end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 16,
    parameter int IMM_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [7:0]            opcode,
    input  logic [IMM_W-1:0]      imm,
    input  logic [ADDR_W-1:0]     base,
    input  logic [OFF_W-1:0]      offset,
    input  logic [DATA_W-1:0]     src_val,
    input  logic [DATA_W-1:0]     r0_val,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    output logic                  lock,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic [DATA_W/8-1:0]   mem_wmask,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  wb_en,
    output logic                  wb_to_r0,
    output logic [DATA_W-1:0]     wb_data
);
    localparam int MASK_W = DATA_W / 8;
    localparam logic [MASK_W-1:0] NARROW_MASK = MASK_W'({(MASK_W/2){1'b1}});

    amo_state_t        state;
    amo_cmd_t          dec_cmd;
    amo_cmd_t          cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] cmp_q;
    logic [DATA_W-1:0] new_q;
    logic [DATA_W-1:0] fetched_q;
    logic              err_q;
    logic              wb_en_q;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] alu_new;
    logic [DATA_W-1:0] alu_fetched;
    logic              alu_write;

    amo_decode #(.IMM_W(IMM_W)) u_decode (
        .opcode (opcode),
        .imm    (imm),
        .cmd    (dec_cmd)
    );

    amo_alu #(.DATA_W(DATA_W)) u_alu (
        .cmd      (cmd_q),
        .mem_old  (mem_rdata),
        .src      (src_q),
        .cmp      (cmp_q),
        .new_val  (alu_new),
        .fetched  (alu_fetched),
        .do_write (alu_write)
    );

    assign eff_addr = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cmd_q     <= '0;
            addr_q    <= '0;
            src_q     <= '0;
            cmp_q     <= '0;
            new_q     <= '0;
            fetched_q <= '0;
            err_q     <= 1'b0;
            wb_en_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cmd_q     <= dec_cmd;
                        addr_q    <= eff_addr;
                        src_q     <= src_val;
                        cmp_q     <= r0_val;
                        err_q     <= !dec_cmd.legal;
                        wb_en_q   <= 1'b0;
                        fetched_q <= '0;
                        state     <= dec_cmd.legal ? ST_READ : ST_DONE;
                    end
                end
                ST_READ:   state <= ST_MODIFY;
                ST_MODIFY: begin
                    new_q     <= alu_new;
                    fetched_q <= alu_fetched;
                    wb_en_q   <= cmd_q.fetch;
                    state     <= alu_write ? ST_WRITE : ST_DONE;
                end
                ST_WRITE:  state <= ST_DONE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        lock      = (state == ST_READ) || (state == ST_MODIFY) || (state == ST_WRITE);
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_addr  = addr_q;
        mem_wdata = new_q;
        mem_wmask = cmd_q.narrow ? NARROW_MASK : '1;
        err       = done && err_q;
        wb_en     = done && wb_en_q;
        wb_to_r0  = done && !err_q && (cmd_q.kind == K_CMPX);
        wb_data   = fetched_q;
    end
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
    parameter int ADDR_W = 64,
    parameter int MASK_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              lock,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [MASK_W-1:0] mem_wmask,
    input logic              wb_en
);
    localparam logic [MASK_W-1:0] HALF_MASK = MASK_W'({(MASK_W/2){1'b1}});

    p_mask_shape_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wmask == '1 || mem_wmask == HALF_MASK));

    p_wb_in_done_r3: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);

    p_same_addr_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr == $past(mem_addr, 2) && $past(mem_req, 2)));

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> !$past(mem_req));

    p_lock_cover_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> lock);

    p_read_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> !mem_req);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!lock && !mem_req && !done));
endmodule

bind amo_unit amo_unit_chk #(.ADDR_W(ADDR_W), .MASK_W(DATA_W/8)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .lock      (lock),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wmask (mem_wmask),
    .wb_en     (wb_en)
);

// File: tb/amo_unit_test.sv
module amo_unit_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [31:0] imm = '0;
    logic [63:0] base = '0;
    logic [15:0] offset = '0;
    logic [63:0] src_val = '0;
    logic [63:0] r0_val = '0;
    logic        busy, done, err, lock, mem_req, mem_we, wb_en, wb_to_r0;
    logic [63:0] mem_addr, mem_wdata, wb_data;
    logic [7:0]  mem_wmask;
    logic [63:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    amo_unit uut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .imm(imm),
        .base(base), .offset(offset), .src_val(src_val), .r0_val(r0_val),
        .busy(busy), .done(done), .err(err), .lock(lock),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_rdata(mem_rdata),
        .wb_en(wb_en), .wb_to_r0(wb_to_r0), .wb_data(wb_data)
    );

    // Zero-wait memory, eight words
    logic [63:0] mem    [8];
    logic [63:0] shadow [8];

    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[5:3]];
        if (mem_req && mem_we)
            for (int b = 0; b < 8; b++)
                if (mem_wmask[b]) mem[mem_addr[5:3]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end

    typedef struct {
        int          rq;
        bit          err;
        bit          wben;
        bit          wbr0;
        logic [63:0] wbd;
        int          idx;
        logic [63:0] mem_after;
        bit          wr;
        int          cyc;
        logic [63:0] addr;
    } exp_t;

    exp_t q[$];

    task automatic chk(bit ok, int rq, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Scoreboard monitor
    int  cyc_cnt = 0;
    bit  wrote = 1'b0;
    bit  read_seen = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) cyc_cnt++;
            if (mem_req && !mem_we && q.size() > 0 && !read_seen) begin
                read_seen = 1'b1;
                chk(mem_addr == q[0].addr, 7, "read address", mem_addr, q[0].addr);   // R7
                chk(cyc_cnt == 1, 10, "read cycle", 64'(cyc_cnt), 64'd1);              // R10
            end
            if (mem_req && mem_we) begin
                wrote = 1'b1;
                if (q.size() > 0)
                    chk(mem_addr == q[0].addr, 7, "write address", mem_addr, q[0].addr);
            end
            if (done) begin
                if (q.size() == 0) begin
                    chk(1'b0, 12, "unexpected done", 64'd1, 64'd0);                  // R12
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(err == e.err, e.rq, "err", 64'(err), 64'(e.err));
                    chk(wb_en == e.wben, e.rq, "wb_en", 64'(wb_en), 64'(e.wben));
                    chk(wb_to_r0 == e.wbr0, e.rq, "wb_to_r0", 64'(wb_to_r0), 64'(e.wbr0));
                    if (e.wben || e.wbr0)
                        chk(wb_data == e.wbd, e.rq, "wb_data", wb_data, e.wbd);
                    chk(mem[e.idx] == e.mem_after, e.rq, "memory word", mem[e.idx], e.mem_after);
                    chk(wrote == e.wr, e.rq, "write issued", 64'(wrote), 64'(e.wr));
                    chk(cyc_cnt == e.cyc, 10, "cycles to done", 64'(cyc_cnt), 64'(e.cyc)); // R10
                end
                cyc_cnt   = 0;
                wrote     = 1'b0;
                read_seen = 1'b0;
            end
        end
    end

    // Driver: computes expectation from the requirements, pushes it, drives the request
    task automatic run_op(int rq, logic [7:0] opc, logic [31:0] op, logic [63:0] b,
                          logic [15:0] off, logic [63:0] s, bit r0_match, bit glitch);
        exp_t        e;
        logic [63:0] addr, old, lm, m, sv, cv, r, r0v;
        bit          legal, narrow;
        addr   = b + {{48{off[15]}}, off};
        e.idx  = int'(addr[5:3]);
        old    = shadow[e.idx];
        narrow = (opc == 8'hc3);
        legal  = (opc == 8'hdb || opc == 8'hc3) &&
                 (op inside {32'h00, 32'h01, 32'h40, 32'h41, 32'h50, 32'h51,
                             32'ha0, 32'ha1, 32'he1, 32'hf1});
        lm  = narrow ? 64'h0000_0000_FFFF_FFFF : 64'hFFFF_FFFF_FFFF_FFFF;
        r0v = r0_match ? (narrow ? {32'hDEAD_BEEF, old[31:0]} : old) : (old ^ 64'h1);
        m   = old & lm;
        sv  = s & lm;
        cv  = r0v & lm;
        case (op[7:0])
            8'h00, 8'h01: r = m + sv;
            8'h40, 8'h41: r = m | sv;
            8'h50, 8'h51: r = m & sv;
            8'ha0, 8'ha1: r = m ^ sv;
            default:      r = sv;
        endcase
        e.rq   = rq;
        e.addr = addr;
        e.err  = !legal;
        e.wr   = legal && (op != 32'hf1 || m == cv);
        e.wben = legal && op[0];
        e.wbr0 = legal && (op == 32'hf1);
        e.wbd  = m;
        e.mem_after = !e.wr ? old : (narrow ? {old[63:32], r[31:0]} : r);
        e.cyc  = !legal ? 1 : (e.wr ? 4 : 3);
        shadow[e.idx] = e.mem_after;

        @(negedge clk);
        while (busy) @(negedge clk);
        q.push_back(e);
        opcode = opc; imm = op; base = b; offset = off; src_val = s; r0_val = r0v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (glitch) begin
            opcode = 8'hdb; imm = 32'h00; src_val = 64'hFFFF; offset = 16'h0000;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            mem[i]    = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0101_1111_0000_1111);
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R11: quiet during reset
        chk(!busy && !done && !err && !lock && !mem_req, 11, "reset outputs", {busy, done, err, lock, mem_req}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !err && !lock && !mem_req, 11, "idle outputs", {busy, done, err, lock, mem_req}, 64'd0);

        run_op(2, 8'hdb, 32'h00, 64'h1000, 16'h0008, 64'h0000_0001_0000_0005, 1'b0, 1'b0); // R2 add, R1 wide
        run_op(3, 8'hdb, 32'h41, 64'h1010, 16'hFFF8, 64'hF000_0000_0000_000F, 1'b0, 1'b0); // R3 or+fetch, R7 negative offset
        run_op(3, 8'hdb, 32'h51, 64'h1000, 16'h0010, 64'h00FF_00FF_00FF_00FF, 1'b0, 1'b0); // R3 and+fetch
        run_op(2, 8'hdb, 32'ha0, 64'h1000, 16'h0018, 64'hAAAA_5555_AAAA_5555, 1'b0, 1'b0); // R2 xor
        run_op(3, 8'hdb, 32'ha1, 64'h1000, 16'h0018, 64'h1234_0000_0000_4321, 1'b0, 1'b0); // R3 xor+fetch
        run_op(4, 8'hdb, 32'he1, 64'h1020, 16'h0000, 64'hCAFE_F00D_1234_5678, 1'b0, 1'b0); // R4 exchange
        run_op(5, 8'hdb, 32'hf1, 64'h1000, 16'h0028, 64'h5A5A_5A5A_5A5A_5A5A, 1'b1, 1'b0); // R5 cmpxchg hit
        run_op(6, 8'hdb, 32'hf1, 64'h1000, 16'h0030, 64'h7777_7777_7777_7777, 1'b0, 1'b0); // R6 cmpxchg miss
        run_op(1, 8'hc3, 32'h01, 64'h1000, 16'h0038, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 1'b0); // R1 narrow add with carry
        run_op(8, 8'hc3, 32'hf1, 64'h1000, 16'h0000, 64'h0BAD_0BAD_1357_9BDF, 1'b1, 1'b0); // R8 narrow compare on low word
        run_op(8, 8'hc3, 32'he1, 64'h1000, 16'h0010, 64'h9999_9999_2468_ACE0, 1'b0, 1'b0); // R8 zero-extended fetch
        run_op(9, 8'hdb, 32'h02, 64'h1000, 16'h0008, 64'h1, 1'b0, 1'b0);                   // R9 unknown code
        run_op(9, 8'h7b, 32'h00, 64'h1000, 16'h0008, 64'h1, 1'b0, 1'b0);                   // R9 unknown opcode
        run_op(9, 8'hc3, 32'h0000_0100, 64'h1000, 16'h0008, 64'h1, 1'b0, 1'b0);            // R9 high immediate bits
        run_op(12, 8'hdb, 32'h01, 64'h1000, 16'h0020, 64'h0000_0000_0000_0003, 1'b0, 1'b1); // R12 start while busy
        run_op(12, 8'hc3, 32'h40, 64'h1000, 16'h0028, 64'h0000_0000_8000_0001, 1'b0, 1'b1); // R12 on narrow op

        repeat (4) @(negedge clk);
        chk(q.size() == 0, 12, "pending results", 64'(q.size()), 64'd0);
        for (int i = 0; i < 8; i++)
            chk(mem[i] == shadow[i], 1, "final memory image", mem[i], shadow[i]);   // R1
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule